// File: doc/BRIEF.md
# Simplex Parallel Link Transmit Controller

This block drives the sending end of a one-way, point-to-point parallel data link. It announces its presence with an outgoing interconnect level. It opens a connection only while the far end's interconnect level is present. While the request is pending it holds a 32-bit connection-control word on the data lines and waits for the far end to accept. A refusal, a timeout and a deliberate close each return the controller to idle. It never retries by itself.

Once connected, the controller takes packets from a valid/ready word stream with a last-word flag. It cuts each packet into bursts of up to 256 words. A burst may start only when a flow-control credit is available, and each ready pulse from the far end grants one credit. Every burst ends with a check word. A packet level frames all bursts of a packet, and a burst level marks the cycles in which words are actually driven. Each byte lane on the data lines carries odd parity.

Top module: `plsrc_ctrl`

## Requirements
- R1: After reset, lk_ic_out is 1 from the first clock edge onwards, and lk_req, lk_pkt and lk_burst are 0.
- R2: lk_req rises only after lk_ic_in has been seen high. While the request is pending, lk_data carries the value cfg_ctrl_word had in the cycle the request began, even if cfg_ctrl_word changes later.
- R3: If lk_conn rises and then falls before any burst of the connection has started, a one-cycle rej_pulse is given in the first cycle with lk_req low. No new request follows while cmd_open stays high.
- R4: If lk_conn never rises, lk_req stays high for exactly cfg_timeout+1 cycles. A one-cycle tmo_pulse is then given in the first cycle with lk_req low, rej_pulse stays 0, and there is no retry while cmd_open stays high.
- R5: Dropping cmd_open withdraws a pending request with no status pulse. It also closes an open connection once no packet is in progress. In both cases lk_req falls one cycle after cmd_open is sampled low.
- R6: Each rising edge on lk_ready adds one credit. The count saturates at 127, so at least 63 credits can be held. Starting a burst consumes one credit. With no credit, the controller stalls without losing words.
- R7: Packet words appear on lk_data in order. Each burst carries 256 words, except the final burst of a packet, which may be shorter.
- R8: After the last word of each burst there is one cycle with lk_burst=1 and lk_chk=1. In that cycle lk_data is the bitwise XOR of the burst's words. The next cycle has lk_burst=0.
- R9: In every cycle, lk_par[i] is the odd parity of lk_data[8*i+7:8*i], for i = 0 to 3.
- R10: lk_pkt is high at least one cycle before a packet's first word and stays high through every burst of the packet. It falls only after the check word of the packet's final burst, and it is low for at least one cycle between packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_open | input | 1 | Level: 1 requests or keeps a connection, 0 aborts or closes |
| cfg_ctrl_word | input | 32 | Connection-control word sent with the request |
| cfg_timeout | input | TMO_W | Request timeout in cycles |
| s_valid | input | 1 | User word valid |
| s_data | input | 32 | User word |
| s_last | input | 1 | Marks the final word of a packet |
| s_ready | output | 1 | Controller accepts the word this cycle |
| conn_up | output | 1 | Connection open |
| rej_pulse | output | 1 | One-cycle rejection status |
| tmo_pulse | output | 1 | One-cycle timeout status |
| lk_ic_out | output | 1 | Outgoing interconnect level |
| lk_ic_in | input | 1 | Far-end interconnect level |
| lk_req | output | 1 | Connection request level |
| lk_conn | input | 1 | Far-end accept level |
| lk_ready | input | 1 | Far-end ready pulses, one credit per rising edge |
| lk_pkt | output | 1 | Packet framing level |
| lk_burst | output | 1 | Word or check word driven this cycle |
| lk_chk | output | 1 | lk_data holds the burst check word |
| lk_data | output | 32 | Link data lines |
| lk_par | output | 4 | Odd parity, one bit per byte of lk_data |

## Verification
The hardest state to reach from the ports is a credit store that is full while data is waiting. It can only be reached by sending more than 127 ready pulses before any word is offered. The bench floods the credits first and then queues 130 one-word packets. Exactly 1+127 bursts must leave before the controller stalls, and three further pulses must release exactly three more. A stall with a packet already framed but no credit is reached by offering a packet before any ready pulse. Random packet lengths with random valid gaps then cover the split of packets into full bursts and a short final burst.

// File: rtl/plsrc_pkg.sv
package plsrc_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {C_IDLE, C_REQ, C_OPEN, C_HOLD} conn_e;
  typedef enum logic [1:0] {B_IDLE, B_DATA, B_CHK, B_GAP} bst_e;

  // one bit per byte lane, set so that each lane plus its bit has odd weight
  function automatic logic [LANES-1:0] odd_par(input logic [WORD_W-1:0] w);
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) p[i] = ~(^w[8*i +: 8]);
    return p;
  endfunction
endpackage

// File: rtl/plsrc_credit.sv
module plsrc_credit #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rdy_in,
  input  logic          take,
  output logic          avail,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  logic prev;
  logic rise;

  assign rise  = rdy_in & ~prev;
  assign avail = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= rdy_in;
      if (clr) cnt <= '0;
      else begin
        case ({rise, take})
          2'b10:   if (cnt != CMAX) cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end
  end
endmodule

// File: rtl/plsrc_conn.sv
module plsrc_conn
  import plsrc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_open,
  input  logic [WORD_W-1:0] ctrl_in,
  input  logic [TW-1:0]     tmo_lim,
  input  logic              ic_in,
  input  logic              conn_in,
  input  logic              fr_idle,
  input  logic              fr_sent,
  output conn_e             st,
  output logic              link_open,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              rej_p,
  output logic              tmo_p
);
  logic [TW-1:0] tcnt;

  assign link_open = (st == C_OPEN) && conn_in && ic_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= C_IDLE;
      tcnt   <= '0;
      ctrl_q <= '0;
      rej_p  <= 1'b0;
      tmo_p  <= 1'b0;
    end else begin
      rej_p <= 1'b0;
      tmo_p <= 1'b0;
      case (st)
        C_IDLE: if (cmd_open && ic_in) begin
          st     <= C_REQ;
          ctrl_q <= ctrl_in;
          tcnt   <= '0;
        end
        C_REQ: begin
          if (!cmd_open || !ic_in) st <= C_IDLE;
          else if (conn_in) st <= C_OPEN;
          else if (tcnt == tmo_lim) begin
            st    <= C_HOLD;
            tmo_p <= 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        C_OPEN: begin
          if (!conn_in || !ic_in) begin
            st    <= C_HOLD;
            rej_p <= !conn_in && !fr_sent;
          end else if (!cmd_open && fr_idle) st <= C_HOLD;
        end
        C_HOLD: if (!cmd_open && !conn_in) st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/plsrc_burst.sv
module plsrc_burst
  import plsrc_pkg::*;
#(
  parameter int BL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_open,
  input  logic              credit_avail,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              take,
  output logic              pkt,
  output logic              bst,
  output logic              chk,
  output logic [WORD_W-1:0] data,
  output logic              sent,
  output logic              idle
);
  localparam int BW = $clog2(BL);
  localparam logic [BW-1:0] LAST_IDX = BW'(BL - 1);

  bst_e              bs;
  logic [BW-1:0]     wcnt;
  logic [WORD_W-1:0] acc;
  logic              last_q;

  assign s_ready = link_open && (bs == B_DATA);
  assign take    = link_open && (bs == B_IDLE) && pkt && s_valid && credit_avail;
  assign idle    = (bs == B_IDLE) && !pkt;

  always_ff @(posedge clk) begin
    if (!rst_n || !link_open) begin
      bs     <= B_IDLE;
      pkt    <= 1'b0;
      bst    <= 1'b0;
      chk    <= 1'b0;
      data   <= '0;
      sent   <= 1'b0;
      wcnt   <= '0;
      acc    <= '0;
      last_q <= 1'b0;
    end else begin
      bst <= 1'b0;
      chk <= 1'b0;
      case (bs)
        B_IDLE: begin
          if (s_valid && !pkt) pkt <= 1'b1;
          else if (take) begin
            bs   <= B_DATA;
            wcnt <= '0;
            acc  <= '0;
            sent <= 1'b1;
          end
        end
        B_DATA: if (s_valid) begin
          data <= s_data;
          bst  <= 1'b1;
          acc  <= acc ^ s_data;
          wcnt <= wcnt + 1'b1;
          if (s_last || wcnt == LAST_IDX) begin
            bs     <= B_CHK;
            last_q <= s_last;
          end
        end
        B_CHK: begin
          data <= acc;
          bst  <= 1'b1;
          chk  <= 1'b1;
          bs   <= B_GAP;
        end
        B_GAP: begin
          if (last_q) pkt <= 1'b0;
          data <= '0;
          bs   <= B_IDLE;
        end
        default: bs <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/plsrc_ctrl.sv
module plsrc_ctrl
  import plsrc_pkg::*;
#(
  parameter int BURST_LEN = 256,
  parameter int CREDIT_W  = 7,
  parameter int TMO_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_open,
  input  logic [31:0]       cfg_ctrl_word,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic              s_valid,
  input  logic [31:0]       s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              conn_up,
  output logic              rej_pulse,
  output logic              tmo_pulse,
  output logic              lk_ic_out,
  input  logic              lk_ic_in,
  output logic              lk_req,
  input  logic              lk_conn,
  input  logic              lk_ready,
  output logic              lk_pkt,
  output logic              lk_burst,
  output logic              lk_chk,
  output logic [31:0]       lk_data,
  output logic [3:0]        lk_par
);
  conn_e               conn_st;
  logic                link_open_w;
  logic [WORD_W-1:0]   ctrl_q;
  logic                take_w;
  logic                credit_ok;
  logic [CREDIT_W-1:0] credit_cnt;
  logic [WORD_W-1:0]   fr_data;
  logic                fr_sent;
  logic                fr_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) lk_ic_out <= 1'b0;
    else        lk_ic_out <= 1'b1;
  end

  plsrc_conn #(.TW(TMO_W)) u_conn (
    .clk(clk), .rst_n(rst_n), .cmd_open(cmd_open), .ctrl_in(cfg_ctrl_word),
    .tmo_lim(cfg_timeout), .ic_in(lk_ic_in), .conn_in(lk_conn),
    .fr_idle(fr_idle), .fr_sent(fr_sent), .st(conn_st),
    .link_open(link_open_w), .ctrl_q(ctrl_q), .rej_p(rej_pulse), .tmo_p(tmo_pulse)
  );

  plsrc_credit #(.CW(CREDIT_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .clr(conn_st != C_OPEN), .rdy_in(lk_ready),
    .take(take_w), .avail(credit_ok), .cnt(credit_cnt)
  );

  plsrc_burst #(.BL(BURST_LEN)) u_burst (
    .clk(clk), .rst_n(rst_n), .link_open(link_open_w), .credit_avail(credit_ok),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .take(take_w), .pkt(lk_pkt), .bst(lk_burst), .chk(lk_chk), .data(fr_data),
    .sent(fr_sent), .idle(fr_idle)
  );

  assign conn_up = (conn_st == C_OPEN);
  assign lk_req  = (conn_st == C_REQ) || (conn_st == C_OPEN);
  assign lk_data = (conn_st == C_REQ) ? ctrl_q : fr_data;
  assign lk_par  = odd_par(lk_data);
endmodule

// File: rtl/plsrc_chk.sv
module plsrc_chk #(
  parameter int BL = 256,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_ic_in,
  input logic          lk_ic_out,
  input logic          lk_req,
  input logic          lk_conn,
  input logic          lk_pkt,
  input logic          lk_burst,
  input logic          lk_chk,
  input logic          rej_pulse,
  input logic          tmo_pulse,
  input logic          take,
  input logic [CW-1:0] ccnt
);
  logic [15:0] wc;

  always_ff @(posedge clk) begin
    if (!rst_n)                  wc <= '0;
    else if (lk_chk)             wc <= '0;
    else if (lk_burst)           wc <= wc + 1'b1;
  end

  a_r1_ic_out: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> lk_ic_out);
  a_r2_req_after_ic: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lk_req) |-> $past(lk_ic_in));
  a_r3_rej_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |-> !lk_req);
  a_r4_tmo_not_rej: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> (!rej_pulse && !lk_req));
  a_r6_credit_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ccnt != '0);
  a_r7_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_burst && !lk_chk) |-> wc < 16'(BL));
  a_r8_chk_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    lk_chk |-> wc != '0);
  a_r8_gap_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_chk |=> !lk_burst);
  a_r10_burst_in_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    lk_burst |-> lk_pkt);
  a_r10_pkt_after_conn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lk_pkt) |-> $past(lk_conn));
endmodule

bind plsrc_ctrl plsrc_chk #(.BL(BURST_LEN), .CW(CREDIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_ic_in(lk_ic_in), .lk_ic_out(lk_ic_out),
  .lk_req(lk_req), .lk_conn(lk_conn), .lk_pkt(lk_pkt), .lk_burst(lk_burst),
  .lk_chk(lk_chk), .rej_pulse(rej_pulse), .tmo_pulse(tmo_pulse),
  .take(take_w), .ccnt(credit_cnt)
);

// File: tb/plsrc_ctrl_bench.sv
module plsrc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_open = 1'b0;
  logic [31:0] cfg_ctrl_word = 32'h0;
  logic [15:0] cfg_timeout = 16'd10;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = 32'h0;
  logic        s_last = 1'b0;
  logic        s_ready, conn_up, rej_pulse, tmo_pulse, lk_ic_out;
  logic        lk_ic_in = 1'b0, lk_conn = 1'b0, lk_ready = 1'b0;
  logic        lk_req, lk_pkt, lk_burst, lk_chk;
  logic [31:0] lk_data;
  logic [3:0]  lk_par;

  always #10 clk = ~clk;

  plsrc_ctrl u_plsrc_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_open(cmd_open), .cfg_ctrl_word(cfg_ctrl_word),
    .cfg_timeout(cfg_timeout), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .conn_up(conn_up), .rej_pulse(rej_pulse), .tmo_pulse(tmo_pulse),
    .lk_ic_out(lk_ic_out), .lk_ic_in(lk_ic_in), .lk_req(lk_req), .lk_conn(lk_conn),
    .lk_ready(lk_ready), .lk_pkt(lk_pkt), .lk_burst(lk_burst), .lk_chk(lk_chk),
    .lk_data(lk_data), .lk_par(lk_par)
  );

  int nchk = 0, nbad = 0;
  logic [31:0] wq[$];
  bit          lq[$];
  int pi = 0, mi = 0, bw = 0, bursts = 0, credits = 0, tmo_seen = 0;
  bit acc_q = 0, exp_gap = 0, last_seen = 1, prev_pkt = 0, gappy = 1;
  logic [31:0] xacc = 0;

  function automatic logic [3:0] par_of(input logic [31:0] w);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ($countones(w[8*i +: 8]) % 2 == 0);
    return p;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic add_pkt(input int n);
    for (int i = 0; i < n; i++) begin
      wq.push_back($urandom);
      lq.push_back(i == n - 1);
    end
  endtask

  task automatic give_ready(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) lk_ready = 1'b1;
      @(negedge clk) lk_ready = 1'b0;
      credits++;
    end
  endtask

  task automatic wait_drain();
    while (mi < wq.size()) @(negedge clk);
    repeat (8) @(negedge clk);
    #1;
  endtask

  // word source
  always @(negedge clk) begin
    if (acc_q) pi++;
    if (pi < wq.size() && (!gappy || $urandom_range(0, 3) != 0)) begin
      s_valid = 1'b1; s_data = wq[pi]; s_last = lq[pi];
    end else s_valid = 1'b0;
    acc_q = s_valid && s_ready;
  end

  // link monitor
  always @(negedge clk) if (rst_n) begin
    if (tmo_pulse) tmo_seen++;
    if (lk_burst || lk_req) chk(lk_par == par_of(lk_data), "R9 parity", {28'h0, lk_par}, {28'h0, par_of(lk_data)});
    if (lk_burst && !lk_chk) begin
      if (bw == 0 && last_seen) chk(prev_pkt, "R10 pkt before first word", {31'h0, prev_pkt}, 32'h1);
      if (mi < wq.size()) begin
        chk(lk_data == wq[mi], "R7 word order", lk_data, wq[mi]);
        last_seen = lq[mi];
      end else chk(0, "R7 extra word", lk_data, 32'h0);
      xacc ^= lk_data; bw++; mi++;
    end else if (lk_chk) begin
      chk(lk_data == xacc, "R8 check word", lk_data, xacc);
      chk(bw == 256 || (bw < 256 && last_seen), "R7 burst length", bw, 256);
      chk(lk_pkt, "R10 pkt over burst", {31'h0, lk_pkt}, 32'h1);
      bursts++;
      chk(bursts <= credits, "R6 burst needs credit", bursts, credits);
      xacc = 0; bw = 0; exp_gap = 1;
    end else if (exp_gap) begin
      chk(!lk_burst, "R8 idle after check", {31'h0, lk_burst}, 32'h0);
      exp_gap = 0;
    end
    if (prev_pkt && !lk_pkt) chk(bw == 0 && last_seen, "R10 pkt falls after final burst", bw, 0);
    prev_pkt = lk_pkt;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] cw;
    int seen;
    void'($urandom(32'h1234_5678));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(lk_ic_out == 1'b1, "R1 ic out", {31'h0, lk_ic_out}, 32'h1);
    chk({lk_req, lk_pkt, lk_burst} == 3'b000, "R1 idle outputs", {29'h0, lk_req, lk_pkt, lk_burst}, 32'h0);

    // R2: no request without far-end interconnect
    cw = $urandom; cfg_ctrl_word = cw; cmd_open = 1'b1; cfg_timeout = 16'd10;
    seen = 0;
    repeat (20) begin @(negedge clk); #1; if (lk_req) seen++; end
    chk(seen == 0, "R2 no req without ic", seen, 0);
    lk_ic_in = 1'b1;
    do begin @(negedge clk); #1; end while (!lk_req);
    cfg_ctrl_word = ~cw;
    chk(lk_data == cw, "R2 ctrl word", lk_data, cw);
    // R4 timeout
    cyc = 0;
    while (lk_req) begin
      cyc++;
      if (cyc == 3) chk(lk_data == cw, "R2 ctrl word held", lk_data, cw);
      @(negedge clk); #1;
    end
    chk(cyc == 11, "R4 request length", cyc, 11);
    chk(tmo_pulse && !rej_pulse, "R4 timeout pulse", {30'h0, tmo_pulse, rej_pulse}, 32'h2);
    seen = 0;
    repeat (20) begin @(negedge clk); #1; if (lk_req) seen++; end
    chk(seen == 0, "R4 no retry", seen, 0);
    cmd_open = 1'b0; repeat (3) @(negedge clk);

    // R5 abort of pending request
    cmd_open = 1'b1; tmo_seen = 0;
    do begin @(negedge clk); #1; end while (!lk_req);
    repeat (3) @(negedge clk);
    cmd_open = 1'b0;
    @(negedge clk); #1;
    chk(!lk_req, "R5 abort drops req", {31'h0, lk_req}, 32'h0);
    repeat (20) @(negedge clk); #1;
    chk(tmo_seen == 0 && !rej_pulse, "R5 abort no status", tmo_seen, 0);

    // R3 rejection
    cmd_open = 1'b1;
    do begin @(negedge clk); #1; end while (!lk_req);
    lk_conn = 1'b1;
    repeat (3) @(negedge clk);
    lk_conn = 1'b0;
    @(negedge clk); #1;
    chk(rej_pulse && !tmo_pulse && !lk_req, "R3 reject pulse", {29'h0, rej_pulse, tmo_pulse, lk_req}, 32'h4);
    seen = 0;
    repeat (20) begin @(negedge clk); #1; if (lk_req || rej_pulse) seen++; end
    chk(seen == 0, "R3 no retry", seen, 0);
    cmd_open = 1'b0; repeat (3) @(negedge clk);

    // open a real connection
    cfg_timeout = 16'd1000; cmd_open = 1'b1;
    do begin @(negedge clk); #1; end while (!lk_req);
    lk_conn = 1'b1;
    repeat (3) @(negedge clk);

    // R6 stall with no credit
    add_pkt(5);
    repeat (30) @(negedge clk); #1;
    chk(bursts == 0, "R6 stall at zero credit", bursts, 0);
    chk(lk_pkt, "R10 pkt up while stalled", {31'h0, lk_pkt}, 32'h1);
    give_ready(1);
    wait_drain();
    chk(bursts == 1, "R6 one credit one burst", bursts, 1);

    // R6 saturation
    gappy = 0;
    give_ready(140);
    for (int k = 0; k < 130; k++) add_pkt(1);
    repeat (1500) @(negedge clk); #1;
    chk(bursts == 128, "R6 credit saturates at 127", bursts, 128);
    give_ready(3);
    wait_drain();
    chk(bursts == 131, "R6 credits after saturation", bursts, 131);

    // R7 directed lengths then random
    gappy = 1;
    give_ready(12);
    add_pkt(256); add_pkt(257); add_pkt(512); add_pkt(255);
    wait_drain();
    chk(bursts == 131 + 1 + 2 + 2 + 1, "R7 bursts per packet", bursts, 137);
    give_ready(40);
    for (int k = 0; k < 10; k++) add_pkt($urandom_range(1, 700));
    wait_drain();
    chk(mi == wq.size(), "R7 all words delivered", mi, wq.size());

    // R5 close
    cmd_open = 1'b0;
    @(negedge clk); #1;
    chk(!lk_req && !rej_pulse, "R5 close drops req", {30'h0, lk_req, rej_pulse}, 32'h0);
    lk_conn = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk(!conn_up, "R5 closed", {31'h0, conn_up}, 32'h0);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule